// File: doc/BRIEF.md
# Convert-start gating and power-mode sequencer

This block turns one asynchronous convert-start line into the control a sampling converter core needs. The core sleeps after reset. A rising edge on the start line switches core power on and starts a fixed power-up window of `PWRUP_CYC` clocks. The window and the start line together act as one gated start. The conversion begins when that gated start is released. That moment is the later of two events: the end of the window and the synchronized start line going low.

While a conversion runs, BUSY and the hold control are high. The conversion ends when the core reports done, or after `CONV_CYC` cycles, whichever comes first. On that cycle BUSY falls and a one-cycle result-latch strobe fires. The level of the start line at that moment picks the power mode:

- **High (stay-awake mode):** the core stays powered. The next conversion cannot start until at least `ACQ_CYC` cycles of tracking have passed.
- **Low (auto-sleep mode):** power drops on the same cycle BUSY falls.

No data stream passes through the block, so every pin is a plain control level or a strobe, and there is no handshake or back-pressure. Cycle counts default to values derived from `CLK_MHZ`: 1.5 µs for power-up, 2.3 µs for conversion and 100 ns for acquisition. Each can be overridden.

Top module: `start_gate_seq`

## Requirements
- R1: After reset, `core_pwr_en`, `busy`, `hold`, `conv_start` and `result_latch` are all 0, and they stay 0 for as long as `ext_start` stays low.
- R2: From the powered-down state, a rise of `ext_start` before clock edge 1 makes `core_pwr_en` read 1 after clock edge 3. The input passes through a two-flop synchronizer before edge detection.
- R3: `busy` rises max(`PWRUP_CYC`, H) cycles after `core_pwr_en` rises, where H is the number of cycles `ext_start` was held high. This is the later of the two releases of the gated start.
- R4: `conv_start` is a one-cycle pulse in the first `busy` cycle, and `hold` is 1 exactly while `busy` is 1.
- R5: `busy` stays high until the cycle after `core_done` is sampled 1, and never for more than `CONV_CYC` cycles.
- R6: `result_latch` is 1 for exactly the one cycle in which `busy` first reads 0 after a conversion.
- R7: If the synchronized `ext_start` is 1 when the conversion ends, `core_pwr_en` stays 1 (stay-awake mode).
- R8: If the synchronized `ext_start` is 0 when the conversion ends, `core_pwr_en` reads 0 in the same cycle in which `busy` falls (auto-sleep mode).
- R9: In stay-awake mode, `busy` stays low for at least `ACQ_CYC` cycles between two conversions.
- R10: A rise of `ext_start` during a conversion neither ends nor extends it. A rise while powered and waiting does not restart the power-up window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| ext_start | input | 1 | Asynchronous external convert-start line |
| core_done | input | 1 | Conversion-done indication from the converter core |
| core_pwr_en | output | 1 | Core power enable |
| hold | output | 1 | 1 = sampler holds, 0 = sampler tracks |
| conv_start | output | 1 | One-cycle start strobe to the core |
| busy | output | 1 | Conversion in progress |
| result_latch | output | 1 | One-cycle strobe to latch the result |

## Verification
A wrong state register shows up at the ports within one cycle, because `core_pwr_en`, `busy` and `hold` are decoded directly from it. A wrongly loaded window counter shows up as a shifted BUSY rise or fall, and it is caught on the first conversion. A mode decision taken from the wrong level of the start line shows up as `core_pwr_en` changing in the very cycle BUSY falls. A missing acquisition guard only shows up on the second conversion of a stay-awake run, so the bench times the gap between two back-to-back conversions.

// File: rtl/start_seq_pkg.sv
`timescale 1ns/1ps
package start_seq_pkg;

  typedef enum logic [1:0] {
    SQ_ASLEEP = 2'd0,
    SQ_GATED  = 2'd1,
    SQ_CONV   = 2'd2
  } sq_state_t;

  // Cycles covering a duration in ns at a clock in MHz, rounded up, at least 1.
  function automatic int cycles_for_ns(input int ns, input int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/start_sync.sv
`timescale 1ns/1ps
module start_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[0] <= 1'b0;
        else        sh[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh[i] <= 1'b0;
        else        sh[i] <= sh[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b0;
    else        prev <= sh[STAGES-1];
  end

  assign lvl  = sh[STAGES-1];
  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/window_timer.sv
`timescale 1ns/1ps
module window_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/seq_fsm.sv
`timescale 1ns/1ps
module seq_fsm
  import start_seq_pkg::*;
#(
  parameter int PWRUP_CYC = 30,
  parameter int CONV_CYC  = 46,
  parameter int ACQ_CYC   = 2,
  parameter int TW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ext_lvl,
  input  logic          ext_rise,
  input  logic          core_done,
  input  logic          win_expired,
  output logic          win_load,
  output logic [TW-1:0] win_val,
  output sq_state_t     state,
  output logic          start_q,
  output logic          latch_q
);
  localparam logic [TW-1:0] PW_LD = TW'(PWRUP_CYC - 1);
  localparam logic [TW-1:0] CV_LD = TW'(CONV_CYC - 1);
  localparam logic [TW-1:0] AQ_LD = TW'(ACQ_CYC - 1);

  sq_state_t nxt;
  logic      start_d;
  logic      end_d;

  always_comb begin
    nxt      = state;
    win_load = 1'b0;
    win_val  = '0;
    start_d  = 1'b0;
    end_d    = 1'b0;
    unique case (state)
      SQ_ASLEEP: begin
        if (ext_rise) begin
          nxt      = SQ_GATED;
          win_load = 1'b1;
          win_val  = PW_LD;
        end
      end
      SQ_GATED: begin
        // gated start released only when window is over and line is low
        if (win_expired && !ext_lvl) begin
          nxt      = SQ_CONV;
          win_load = 1'b1;
          win_val  = CV_LD;
          start_d  = 1'b1;
        end
      end
      SQ_CONV: begin
        if (core_done || win_expired) begin
          end_d    = 1'b1;
          win_load = 1'b1;
          win_val  = AQ_LD;
          nxt      = ext_lvl ? SQ_GATED : SQ_ASLEEP;
        end
      end
      default: nxt = SQ_ASLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= SQ_ASLEEP;
      start_q <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      state   <= nxt;
      start_q <= start_d;
      latch_q <= end_d;
    end
  end
endmodule

// File: rtl/start_gate_seq.sv
`timescale 1ns/1ps
module start_gate_seq
  import start_seq_pkg::*;
#(
  parameter int CLK_MHZ     = 20,
  parameter int SYNC_STAGES = 2,
  parameter int PWRUP_CYC   = cycles_for_ns(1500, CLK_MHZ),
  parameter int CONV_CYC    = cycles_for_ns(2300, CLK_MHZ),
  parameter int ACQ_CYC     = cycles_for_ns(100, CLK_MHZ)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_start,
  input  logic core_done,
  output logic core_pwr_en,
  output logic hold,
  output logic conv_start,
  output logic busy,
  output logic result_latch
);
  localparam int MAX_A = (PWRUP_CYC > CONV_CYC) ? PWRUP_CYC : CONV_CYC;
  localparam int MAX_C = (MAX_A > ACQ_CYC) ? MAX_A : ACQ_CYC;
  localparam int TW    = (MAX_C < 2) ? 1 : $clog2(MAX_C);

  logic          ext_lvl;
  logic          ext_rise;
  logic          win_load;
  logic [TW-1:0] win_val;
  logic          win_expired;
  sq_state_t     state;
  logic          start_q;
  logic          latch_q;

  start_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (ext_start),
    .lvl  (ext_lvl),
    .rise (ext_rise)
  );

  window_timer #(.W(TW)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (win_load),
    .load_val(win_val),
    .expired (win_expired)
  );

  seq_fsm #(
    .PWRUP_CYC(PWRUP_CYC),
    .CONV_CYC (CONV_CYC),
    .ACQ_CYC  (ACQ_CYC),
    .TW       (TW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_lvl    (ext_lvl),
    .ext_rise   (ext_rise),
    .core_done  (core_done),
    .win_expired(win_expired),
    .win_load   (win_load),
    .win_val    (win_val),
    .state      (state),
    .start_q    (start_q),
    .latch_q    (latch_q)
  );

  assign core_pwr_en  = (state != SQ_ASLEEP);
  assign busy         = (state == SQ_CONV);
  assign hold         = (state == SQ_CONV);
  assign conv_start   = start_q;
  assign result_latch = latch_q;
endmodule

// File: rtl/start_gate_seq_chk.sv
`timescale 1ns/1ps
module start_gate_seq_chk #(
  parameter int CONV_CYC = 46,
  parameter int ACQ_CYC  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic core_pwr_en,
  input logic hold,
  input logic conv_start,
  input logic busy,
  input logic result_latch
);
  logic [15:0] run_len;
  logic [15:0] gap_len;
  logic        awake_gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len   <= '0;
      gap_len   <= '0;
      awake_gap <= 1'b0;
    end else begin
      run_len <= busy ? run_len + 16'd1 : 16'd0;
      if (busy) gap_len <= '0;
      else if (gap_len != 16'hFFFF) gap_len <= gap_len + 16'd1;
      if (busy) awake_gap <= 1'b1;
      else if (!core_pwr_en) awake_gap <= 1'b0;
    end
  end

  // R1: no conversion without core power
  p_busy_needs_pwr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> core_pwr_en);
  // R4: start strobe marks the first busy cycle
  p_start_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> conv_start);
  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_hold_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold == busy);
  // R5: conversion length bounded
  p_conv_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_len < 16'(CONV_CYC)));
  // R6: latch strobe coincides with busy fall
  p_latch_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> result_latch);
  p_latch_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    result_latch |-> !busy);
  // R9: acquisition guard between stay-awake conversions
  p_acq_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && awake_gap) |-> (gap_len >= 16'(ACQ_CYC)));
endmodule

bind start_gate_seq start_gate_seq_chk #(
  .CONV_CYC(CONV_CYC),
  .ACQ_CYC (ACQ_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .core_pwr_en (core_pwr_en),
  .hold        (hold),
  .conv_start  (conv_start),
  .busy        (busy),
  .result_latch(result_latch)
);

// File: tb/start_gate_seq_tb.sv
`timescale 1ns/1ps
module start_gate_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int CV = 12;
  localparam int AQ = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_start = 1'b0;
  logic core_done = 1'b0;
  logic core_pwr_en, hold, conv_start, busy, result_latch;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  start_gate_seq #(
    .PWRUP_CYC(PW), .CONV_CYC(CV), .ACQ_CYC(AQ)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_start(ext_start), .core_done(core_done),
    .core_pwr_en(core_pwr_en), .hold(hold), .conv_start(conv_start),
    .busy(busy), .result_latch(result_latch)
  );

  // {fall cycle, re-raise offset after busy (0 none), done after, exp busy offset, exp busy len, exp pwr after}
  localparam int NV = 5;
  localparam int VEC [NV][6] = '{
    '{ 2, 0,  5,  8,  5, 0},
    '{14, 0,  4, 14,  4, 0},
    '{ 8, 0, 20,  8, 12, 0},
    '{ 3, 2,  6,  8,  6, 1},
    '{10, 0,  1, 10,  1, 0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ext_start = 1'b0; core_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Starts with ext high at negedge 0; returns first pwr cycle, busy start/end, and flags.
  task automatic run_case(input int h, input int r, input int d,
                          output int pf, output int b, output int e,
                          output int pwr_end, output int lat, output int cs);
    pf = -1; b = -1; e = -1; pwr_end = -1; lat = -1; cs = -1;
    ext_start = 1'b1;
    for (int cyc = 1; cyc < 400; cyc++) begin
      @(negedge clk);
      if (pf < 0 && core_pwr_en) pf = cyc;
      if (b < 0 && busy) begin b = cyc; cs = conv_start; end
      if (b >= 0 && e < 0 && !busy) begin
        e = cyc; pwr_end = core_pwr_en; lat = result_latch;
      end
      if (cyc == h) ext_start = 1'b0;
      if (b >= 0 && r > 0 && cyc == b + r) ext_start = 1'b1;
      core_done = (b >= 0 && e < 0 && cyc == b + d - 1);
      if (e >= 0) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int pf, b, e, pe, lat, cs;
    int zero_ok;
    do_reset();
    // R1: reset state and no action while ext stays low
    zero_ok = 1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (core_pwr_en | busy | hold | conv_start | result_latch) zero_ok = 0;
    end
    check(zero_ok == 1, "R1 outputs idle while asleep", zero_ok, 1);

    for (int v = 0; v < NV; v++) begin
      do_reset();
      run_case(VEC[v][0], VEC[v][1], VEC[v][2], pf, b, e, pe, lat, cs);
      check(pf == 3, "R2 power-up latency", pf, 3);
      check(b - pf == VEC[v][3], "R3 busy start offset", b - pf, VEC[v][3]);
      check(cs == 1, "R4 conv_start on first busy cycle", cs, 1);
      check(e - b == VEC[v][4], "R5 busy length", e - b, VEC[v][4]);
      check(lat == 1, "R6 latch with busy fall", lat, 1);
      @(negedge clk);
      check(result_latch == 1'b0, "R6 latch one cycle", result_latch, 0);
      if (VEC[v][5] == 1) check(pe == 1, "R7 stays powered", pe, 1);
      else                check(pe == 0, "R8 powers down", pe, 0);
    end

    // R9: stay-awake conversion, then release ext right at busy fall
    do_reset();
    run_case(3, 2, 6, pf, b, e, pe, lat, cs);
    check(pe == 1, "R7 awake before second conversion", pe, 1);
    ext_start = 1'b0;
    begin
      int gap;
      int seen;
      gap = 0; seen = 0;
      for (int i = 0; i < 60 && seen == 0; i++) begin
        @(negedge clk);
        gap++;
        if (busy) seen = 1;
      end
      check(gap == AQ, "R9 acquisition gap", gap, AQ);
      check(hold == 1'b1, "R4 hold during busy", hold, 1);
      core_done = 1'b1;
      @(negedge clk);
      core_done = 1'b0;
      check(busy == 1'b0 && core_pwr_en == 1'b0, "R8 auto-sleep after low line",
            {busy, core_pwr_en}, 0);
    end

    // R10: re-rise while powered and waiting must not restart the window
    do_reset();
    begin
      int bb;
      bb = -1;
      ext_start = 1'b1;
      for (int cyc = 1; cyc < 60 && bb < 0; cyc++) begin
        @(negedge clk);
        if (busy) bb = cyc;
        if (cyc == 2) ext_start = 1'b0;
        if (cyc == 4) ext_start = 1'b1;
        if (cyc == 5) ext_start = 1'b0;
      end
      check(bb == PW + 3, "R10 no window restart", bb, PW + 3);
      core_done = 1'b1;
      @(negedge clk);
      core_done = 1'b0;
      check(busy == 1'b0, "R5 done ends conversion", busy, 0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule